// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block sits on the host side of a byte-wide parallel EEPROM and writes a run of bytes into it. A transfer starts with a one-cycle command that carries the first address, the byte count and the completion-detection method. The bytes then arrive one at a time on a valid/ready stream. Each byte is placed on the memory pins as one write cycle: chip enable low, output enable high, and a write-enable pulse with programmable setup, pulse and hold lengths.

Bytes are gathered into page loads. A page holds 128 bytes, and every byte of one load shares the upper address bits. A load ends when the transfer ends, when the next address would fall in a new page, or when the stream stalls long enough to put the device's byte-load window at risk. After each load the block polls the device until its internal programming finishes. It then moves on to the next page or reports the end of the transfer.

Two polling methods are available. The first rereads the last byte written and compares data bit 7 with bit 7 of that byte. The second compares bit 6 across consecutive reads and needs no saved data. Polling is bounded by a cycle budget; if the budget runs out, an error pulse ends the transfer.

Top module: `eeprom_page_writer`

## Requirements
- R1: Outside a transfer (`busy_o` low), chip enable, write enable and output enable are all high and the data bus is not driven.
- R2: While write enable is low, chip enable is low, output enable is high, the data bus is driven, and the address and data outputs stay constant.
- R3: Each write cycle drives chip enable low for T_SETUP cycles before write enable falls, holds write enable low for exactly T_PULSE cycles, and then keeps chip enable low with data driven for T_HOLD cycles.
- R4: The bytes of one page load all have the same address bits above bit 6 (page = address / 128). A transfer that crosses a page boundary becomes separate loads, and each load is followed by its own completion poll.
- R5: The bytes are written in stream order to consecutive addresses, starting at the command's address, and wrap modulo 2^ADDR_W.
- R6: If no byte is offered for STALL_LIMIT cycles while the current page holds at least one loaded byte, the load is closed and polled. Streaming resumes in a new load after the poll completes.
- R7: With poll mode 0 (data compare), a poll read is at the last written address and is judged complete when read bit 7 equals bit 7 of the last byte written.
- R8: With poll mode 1 (toggle compare), programming is judged complete when two consecutive poll reads return the same bit 6.
- R9: A poll read drives chip enable and output enable low and write enable high, releases the data bus for T_READ cycles, and returns both enables high for at least one cycle between reads.
- R10: If polling has run POLL_LIMIT cycles without completion, `timeout_o` pulses for one cycle, `done_o` stays low, and the block returns to idle.
- R11: `done_o` pulses for exactly one cycle after the last page of a transfer completes. A command with a zero byte count raises `done_o` on the next cycle with no bus activity.
- R12: `wready_o` is high only while the block is in a transfer and waiting for a byte, never during a write or poll cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command to begin a transfer (accepted only when idle) |
| base_addr_i | input | ADDR_W | First byte address |
| byte_cnt_i | input | CNT_W | Number of bytes to write |
| poll_mode_i | input | 1 | 0 = bit-7 data compare, 1 = bit-6 toggle compare |
| wdata_i | input | 8 | Stream byte |
| wvalid_i | input | 1 | Stream byte valid |
| wready_o | output | 1 | Stream byte accepted when high with wvalid_i |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| timeout_o | output | 1 | One-cycle pulse when polling gives up |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | 8 | Memory write data |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Memory read data |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
Two events can land in the same cycle: the end of a page and the end of the transfer, which happens when the last byte of a transfer is also the last byte of a page. The bench provokes this with a transfer of exactly 128 bytes that starts at a page boundary. It then checks that exactly one page load of 128 bytes and one poll sequence occur, with no empty extra load, and that a single `done_o` pulse follows. A second run starts 16 bytes before a boundary, where the page close comes first and the transfer end comes later, so the two outcomes can be compared.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WSU,
    ST_WPW,
    ST_WHD,
    ST_RACC,
    ST_RGAP
  } eepg_state_e;

  localparam logic POLL_DATA   = 1'b0;
  localparam logic POLL_TOGGLE = 1'b1;

  // page index of a byte address
  function automatic logic [31:0] page_of(input logic [31:0] a, input int unsigned pb);
    return a / pb;
  endfunction

  // true when the address is the final byte of its page
  function automatic logic last_in_page(input logic [31:0] a, input int unsigned pb);
    return (a % pb) == (pb - 1);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/eepg_phase_timer.sv
module eepg_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/eepg_page_tracker.sv
module eepg_page_tracker #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (init) begin
      cur_addr  <= base;
      remaining <= count;
    end else if (advance) begin
      cur_addr  <= cur_addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/eepg_poll_judge.sv
module eepg_poll_judge
  import eepg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic       mode,
  input  logic [7:0] dq,
  input  logic       ref_b7,
  output logic       settled
);
  logic have_prev;
  logic prev_b6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_b6   <= dq[6];
    end
  end

  assign settled = sample && ((mode == POLL_TOGGLE) ? (have_prev && (dq[6] == prev_b6))
                                                    : (dq[7] == ref_b7));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepg_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int CNT_W       = 16,
  parameter int PAGE_BYTES  = 128,
  parameter int T_SETUP     = 2,
  parameter int T_PULSE     = 4,
  parameter int T_HOLD      = 2,
  parameter int T_READ      = 3,
  parameter int STALL_LIMIT = 12000,
  parameter int POLL_LIMIT  = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              poll_mode_i,
  input  logic [7:0]        wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [7:0]        mem_dq_i,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o
);
  localparam int PH_MAX  = max4(T_SETUP, T_PULSE, T_HOLD, T_READ);
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int STALL_W = $clog2(STALL_LIMIT + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

  eepg_state_e state_q, state_d;

  logic [ADDR_W-1:0] cur_addr, last_addr_q;
  logic [CNT_W-1:0]  remaining;
  logic [7:0]        wdata_q;
  logic              last_b7_q, mode_q, page_loaded;
  logic              done_q, err_q;
  logic [STALL_W-1:0] stall_cnt;
  logic [POLL_W-1:0]  poll_cnt;

  // named internal events
  logic cmd_take, cmd_empty, hs_fire, hold_end, page_close, stall_close;
  logic poll_enter, poll_sample, poll_settled, poll_giveup, ph_expired, ph_load;
  logic [PH_W-1:0] ph_val;

  function automatic logic [PH_W-1:0] phase_len_m1(input eepg_state_e s);
    case (s)
      ST_WSU:  return PH_W'(T_SETUP - 1);
      ST_WPW:  return PH_W'(T_PULSE - 1);
      ST_WHD:  return PH_W'(T_HOLD - 1);
      ST_RACC: return PH_W'(T_READ - 1);
      default: return '0;
    endcase
  endfunction

  assign cmd_take    = (state_q == ST_IDLE) && start_i;
  assign cmd_empty   = cmd_take && (byte_cnt_i == '0);
  assign hs_fire     = (state_q == ST_LOAD) && wvalid_i;
  assign stall_close = (state_q == ST_LOAD) && !wvalid_i && page_loaded &&
                       (stall_cnt >= STALL_W'(STALL_LIMIT - 1));
  assign hold_end    = (state_q == ST_WHD) && ph_expired;
  assign page_close  = (remaining == CNT_W'(1)) ||
                       last_in_page(32'(cur_addr), PAGE_BYTES);
  assign poll_enter  = stall_close || (hold_end && page_close);
  assign poll_sample = (state_q == ST_RACC) && ph_expired;
  assign poll_giveup = poll_sample && !poll_settled &&
                       (poll_cnt >= POLL_W'(POLL_LIMIT - 1));

  eepg_page_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .init(cmd_take), .base(base_addr_i),
    .count(byte_cnt_i), .advance(hold_end), .cur_addr(cur_addr), .remaining(remaining)
  );

  eepg_phase_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_expired)
  );

  eepg_poll_judge u_judge (
    .clk(clk), .rst_n(rst_n), .clear(poll_enter), .sample(poll_sample), .mode(mode_q),
    .dq(mem_dq_i), .ref_b7(last_b7_q), .settled(poll_settled)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_take && !cmd_empty) state_d = ST_LOAD;
      ST_LOAD: begin
        if (hs_fire)          state_d = ST_WSU;
        else if (stall_close) state_d = ST_RACC;
      end
      ST_WSU:  if (ph_expired) state_d = ST_WPW;
      ST_WPW:  if (ph_expired) state_d = ST_WHD;
      ST_WHD:  if (ph_expired) state_d = page_close ? ST_RACC : ST_LOAD;
      ST_RACC: begin
        if (ph_expired) begin
          if (poll_settled)     state_d = (remaining == '0) ? ST_IDLE : ST_LOAD;
          else if (poll_giveup) state_d = ST_IDLE;
          else                  state_d = ST_RGAP;
        end
      end
      ST_RGAP: state_d = ST_RACC;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ph_load = (state_d != state_q) &&
                   (state_d inside {ST_WSU, ST_WPW, ST_WHD, ST_RACC});
  assign ph_val  = phase_len_m1(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wdata_q     <= '0;
      last_addr_q <= '0;
      last_b7_q   <= 1'b0;
      mode_q      <= POLL_DATA;
      page_loaded <= 1'b0;
      stall_cnt   <= '0;
      poll_cnt    <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= cmd_empty || (poll_sample && poll_settled && (remaining == '0));
      err_q   <= poll_giveup;
      if (cmd_take) mode_q <= poll_mode_i;
      if (hs_fire)  wdata_q <= wdata_i;
      if (hold_end) begin
        last_addr_q <= cur_addr;
        last_b7_q   <= wdata_q[7];
      end
      if (cmd_take || (poll_sample && poll_settled) || poll_giveup) page_loaded <= 1'b0;
      else if (hold_end)                                            page_loaded <= 1'b1;
      if (state_q != ST_LOAD || hs_fire)            stall_cnt <= '0;
      else if (stall_cnt != STALL_W'(STALL_LIMIT))  stall_cnt <= stall_cnt + 1'b1;
      if (poll_enter)                                             poll_cnt <= '0;
      else if ((state_q == ST_RACC || state_q == ST_RGAP) &&
               (poll_cnt != POLL_W'(POLL_LIMIT)))                 poll_cnt <= poll_cnt + 1'b1;
    end
  end

  assign wready_o    = (state_q == ST_LOAD);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = err_q;
  assign mem_ce_n_o  = !(state_q inside {ST_WSU, ST_WPW, ST_WHD, ST_RACC});
  assign mem_we_n_o  = (state_q != ST_WPW);
  assign mem_oe_n_o  = (state_q != ST_RACC);
  assign mem_dq_oe_o = (state_q inside {ST_WSU, ST_WPW, ST_WHD});
  assign mem_dq_o    = wdata_q;
  assign mem_addr_o  = (state_q == ST_RACC) ? last_addr_q : cur_addr;

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  // R2
  we_window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R3
  we_fall_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) |-> (!$past(mem_ce_n_o) && $past(mem_dq_oe_o)));

  // R4
  page_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_end && page_loaded) |->
      (page_of(32'(cur_addr), PAGE_BYTES) == page_of(32'(last_addr_q), PAGE_BYTES)));

  // R6
  stall_to_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_close |=> (!mem_oe_n_o && !wready_o));

  // R9
  read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> (!mem_dq_oe_o && mem_we_n_o && !mem_ce_n_o));

  // R10
  giveup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_giveup |=> (timeout_o && !done_o && !busy_o));

  // R12
  ready_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wready_o |-> (busy_o && mem_we_n_o && mem_oe_n_o));
endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
  localparam int AW = 15, CW = 12;
  localparam int TS = 1, TP = 3, TH = 1, TR = 2;
  localparam int STALL = 40, PLIM = 1500, PROG = 300, WINDOW = 60;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0, poll_mode = 1'b0, wvalid = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0] wdata = '0;
  logic wready, busy, done, tmo, dq_oe, ce_n, we_n, oe_n;
  logic [AW-1:0] maddr;
  logic [7:0] dq_o, dq_i;

  eeprom_page_writer #(
    .ADDR_W(AW), .CNT_W(CW), .PAGE_BYTES(128), .T_SETUP(TS), .T_PULSE(TP),
    .T_HOLD(TH), .T_READ(TR), .STALL_LIMIT(STALL), .POLL_LIMIT(PLIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
    .byte_cnt_i(byte_cnt), .poll_mode_i(poll_mode), .wdata_i(wdata), .wvalid_i(wvalid),
    .wready_o(wready), .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i),
    .mem_ce_n_o(ce_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n)
  );

  int checks = 0, errs = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- device model and monitor ----------------
  logic [7:0] mem [int];
  logic [7:0] pg_d[$];
  int         pg_a[$];
  logic [7:0] exp_d[$];
  int         exp_a[$];
  int         bursts[$];
  bit   prog_busy = 0, stuck = 0, tog = 0;
  int   prog_left = 0, cur_burst = 0, burst_page = 0;
  int   last_fall = 0, ce_fall = 0, we_low = 0, poll_t0 = 0, we_falls = 0;
  int   fall_addr = 0;
  logic [7:0] lw_data = '0, fall_data = '0, model_dq = 8'hFF;
  logic p_we = 1, p_oe = 1, p_ce = 1;

  assign dq_i = model_dq;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ce && !ce_n && oe_n) ce_fall = cyc;
      if (p_we && !we_n) begin
        we_falls++;
        chk(cyc - ce_fall == TS, "R3 setup cycles", cyc - ce_fall, TS);
        chk(dq_oe && oe_n && !ce_n, "R2 bus during write", dq_oe, 1);
        chk(!wready, "R12 ready low in write", wready, 0);
        if (cur_burst > 0) chk(cyc - last_fall <= WINDOW, "R4 byte-load window", cyc - last_fall, WINDOW);
        last_fall = cyc; we_low = 0;
        fall_addr = maddr; fall_data = dq_o;
      end
      if (!we_n) we_low++;
      if (!p_we && we_n) begin
        chk(we_low == TP, "R3 pulse width", we_low, TP);
        chk(maddr == fall_addr && dq_o == fall_data, "R2 stable addr/data", dq_o, fall_data);
        if (exp_a.size() == 0) chk(0, "R5 unexpected write", maddr, -1);
        else begin
          int ea; logic [7:0] ed;
          ea = exp_a.pop_front(); ed = exp_d.pop_front();
          chk(maddr == ea, "R5 write address", maddr, ea);
          chk(dq_o == ed, "R5 write data", dq_o, ed);
        end
        if (cur_burst > 0) chk(maddr / 128 == burst_page, "R4 same page", maddr / 128, burst_page);
        else burst_page = maddr / 128;
        cur_burst++;
        pg_a.push_back(maddr); pg_d.push_back(dq_o); lw_data = dq_o;
      end
      if (!p_we && !ce_n && we_n) ; // hold phase
      if (p_oe && !oe_n) begin
        chk(!dq_oe && we_n && !ce_n, "R9 read bus released", dq_oe, 0);
        if (cur_burst > 0) begin
          bursts.push_back(cur_burst); cur_burst = 0;
          prog_busy = 1; prog_left = PROG; poll_t0 = cyc;
        end else if (prog_busy) tog = ~tog;
      end
      if (prog_busy && !stuck) begin
        prog_left--;
        if (prog_left <= 0) begin
          prog_busy = 0;
          while (pg_a.size() > 0) mem[pg_a.pop_front()] = pg_d.pop_front();
        end
      end
      if (prog_busy) model_dq = {~lw_data[7], tog, lw_data[5:0]};
      else if (mem.exists(int'(maddr))) model_dq = mem[int'(maddr)];
      else model_dq = 8'hFF;
    end
    p_we = we_n; p_oe = oe_n; p_ce = ce_n;
    if (cyc > WDOG && !finished) begin
      finished = 1;
      chk(0, "watchdog expired", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // ---------------- driver ----------------
  int cur_xa[$];
  logic [7:0] cur_xd[$];

  task automatic run_xfer(input int base, input int n, input logic mode,
                          input int stall_at, input int stall_len, input int seed);
    @(negedge clk);
    base_addr = AW'(base); byte_cnt = CW'(n); poll_mode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_xa.delete(); cur_xd.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      int a;
      d = 8'((seed * 37 + i * 13) ^ (i << 3));
      a = (base + i) % (1 << AW);
      exp_a.push_back(a); exp_d.push_back(d);
      cur_xa.push_back(a); cur_xd.push_back(d);
      wdata = d; wvalid = 1'b1;
      while (!wready) @(negedge clk);
      @(negedge clk);
      wvalid = 1'b0;
      if (i == stall_at) repeat (stall_len) @(negedge clk);
    end
  endtask

  task automatic wait_end(output bit got_done, output bit got_tmo, output int at);
    got_done = 0; got_tmo = 0; at = 0;
    for (int k = 0; k < 6000; k++) begin
      if (done || tmo) begin
        got_done = done; got_tmo = tmo; at = cyc;
        @(negedge clk);
        chk(!done && !tmo && !busy, "R11 single end pulse", done, 0);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_bursts(input int b0, input int b1, input string tag);
    chk(bursts.size() == ((b1 > 0) ? 2 : 1), tag, bursts.size(), (b1 > 0) ? 2 : 1);
    if (bursts.size() > 0) chk(bursts[0] == b0, tag, bursts[0], b0);
    if (b1 > 0 && bursts.size() > 1) chk(bursts[1] == b1, tag, bursts[1], b1);
    bursts.delete();
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < cur_xa.size(); i++)
      if (!mem.exists(cur_xa[i]) || mem[cur_xa[i]] != cur_xd[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    bit gd, gt;
    int at, falls0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R12 reset state
    chk(ce_n && we_n && oe_n && !dq_oe, "R1 idle bus", {ce_n, we_n, oe_n}, 7);
    chk(!busy && !wready && !done && !tmo, "R12 idle flags", busy, 0);

    // R7: data compare, within one page
    run_xfer(16, 20, 1'b0, -1, 0, 1);
    wait_end(gd, gt, at);
    chk(gd && !gt, "R7 data-poll completes", gd, 1);
    check_bursts(20, 0, "R7 one load");
    check_mem("R5 memory contents data-poll");

    // R8/R4: toggle compare, crossing a page boundary 16 before the end
    run_xfer(240, 40, 1'b1, -1, 0, 2);
    wait_end(gd, gt, at);
    chk(gd && !gt, "R8 toggle-poll completes", gd, 1);
    check_bursts(16, 24, "R4 split at page boundary");
    check_mem("R5 memory contents toggle-poll");

    // R4/R11: page end and transfer end coincide
    run_xfer(256, 128, 1'b1, -1, 0, 3);
    wait_end(gd, gt, at);
    chk(gd && !gt, "R11 aligned full page done", gd, 1);
    check_bursts(128, 0, "R4 aligned full page single load");
    check_mem("R5 memory contents full page");

    // R6: stream stall closes the load early
    run_xfer(768, 10, 1'b0, 4, 100, 4);
    wait_end(gd, gt, at);
    chk(gd && !gt, "R6 stalled transfer done", gd, 1);
    check_bursts(5, 5, "R6 stall splits load");
    check_mem("R5 memory contents stalled");

    // R5: address wrap at top of space
    run_xfer((1 << AW) - 3, 6, 1'b0, -1, 0, 5);
    wait_end(gd, gt, at);
    chk(gd, "R5 wrap transfer done", gd, 1);
    check_bursts(3, 3, "R5 wrap splits into two loads");
    check_mem("R5 memory contents wrap");

    // R11: zero count
    falls0 = we_falls;
    @(negedge clk);
    byte_cnt = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, "R11 zero count done next cycle", done, 1);
    @(negedge clk);
    chk(!done && we_falls == falls0, "R11 zero count no bus activity", we_falls - falls0, 0);

    // R10: timeout in both modes
    for (int m = 0; m < 2; m++) begin
      stuck = 1;
      run_xfer(1024 + m * 128, 3, m[0], -1, 0, 6 + m);
      wait_end(gd, gt, at);
      chk(gt && !gd, "R10 timeout reported", gt, 1);
      chk(at - poll_t0 >= PLIM && at - poll_t0 <= PLIM + TR + 2, "R10 timeout latency",
          at - poll_t0, PLIM);
      check_bursts(3, 0, "R10 single load before timeout");
      stuck = 0; prog_busy = 0; pg_a.delete(); pg_d.delete();
    end

    chk(exp_a.size() == 0, "R5 all expected writes seen", exp_a.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule